// File: doc/BRIEF.md
# Serial BCD Stack with Combine-and-Pop

This block holds a four-level operand stack (X, Y, Z, T) of 14-digit BCD words in one continuously circulating serial loop that is four words long. A bit counter and a word-slot counter name what is at the loop's head at any moment: slot 0 carries X, slot 1 carries Y, slot 2 carries Z and slot 3 carries T. Each word is sent least significant bit first, with digit 0 first. Register contents are never loaded in parallel. Every value moves one bit per clock and is written back at the loop's tail.

A single-cycle start request arms a combine-and-pop operation. The operation begins at the next frame boundary, which is the start of slot 0, and runs for four word times. In the first word time, a serial decimal adder writes X+Y into the X slot. It reads Y from a tap placed one word ahead of the head. In the second and third word times, the tail takes its bits from the same tap, so Z drops into Y and T drops into Z. In the fourth word time, plain recirculation resumes, so T keeps its value and Z and T end up equal.

Outside an operation, a serial write port can replace the bit at the head as it passes. This is how the surrounding logic gives the stack its contents.

Top module: `bcd_serial_stack`

## Requirements
- R1: While reset is held, slot_o and bit_o are 0 and busy_o and carry_o are 0. After reset, all four stack words read as zero.
- R2: bit_o counts 0 to 55 and then wraps to 0. slot_o advances by one, modulo 4, on each wrap. During slot k (0=X, 1=Y, 2=Z, 3=T), head_o carries bit bit_o of word k. Digit i occupies bits 4i..4i+3, and its least significant bit comes first.
- R3: While idle and not writing, every word comes back unchanged in each following frame.
- R4: While idle with wr_en_i high, wr_bit_i replaces the head bit of that cycle. The new bit appears in the same slot and bit position from the next frame on, and the other words are left untouched.
- R5: tap_o always carries the bit one word ahead of the head: during slot k it shows the same bit position of word (k+1) mod 4.
- R6: A start pulse while idle raises busy_o in the first cycle of the next frame (slot 0, bit 0). If the pulse falls in the last cycle of a frame, that next frame begins on the following cycle. busy_o then stays high for exactly 224 cycles.
- R7: After an operation, the stack holds X = (X+Y) mod 10^14 in decimal, Y = old Z, Z = old T, and T = old T.
- R8: The adder applies decimal correction to every digit and carries between digits, so a carry can ripple through a run of nines across the whole word.
- R9: From the start of slot 1 of an operation until the next operation's first word time, carry_o holds the carry out of digit 13 of the sum.
- R10: Start pulses and writes that arrive while busy_o is high have no effect: the result equals R7, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Combine-and-pop request, one cycle |
| wr_en_i | input | 1 | Replace the head bit with wr_bit_i (idle only) |
| wr_bit_i | input | 1 | Serial write data |
| head_o | output | 1 | Bit currently at the loop head |
| tap_o | output | 1 | Bit one word ahead of the head |
| slot_o | output | 2 | Word slot at the head (0 X, 1 Y, 2 Z, 3 T) |
| bit_o | output | $clog2(DIGITS*4) = 6 | Bit position within the word |
| busy_o | output | 1 | Operation in progress |
| carry_o | output | 1 | Carry out of the top digit of the last sum |

## Verification
A written bit is due at the head exactly 224 cycles after the write cycle, in the same slot and bit position. The bench therefore always reads a word at the next occurrence of its slot after the write or the operation has finished. busy_o is due one cycle after the last cycle of the frame in which start was sampled. The bench counts the cycles from the start pulse to busy_o and compares the count with (3−slot)·56 + (55−bit) + 1, then counts 224 busy cycles. carry_o is sampled at slot 1 bit 0 of the operation, the first cycle after the final digit of the sum was settled. All inputs are driven and all outputs sampled on the falling edge.

// File: rtl/bcd_stack_pkg.sv
`timescale 1ns/1ps
package bcd_stack_pkg;
  localparam int DIGIT_W = 4;
  localparam int LEVELS  = 4;

  // Source of the bit that enters the loop tail
  typedef enum logic [1:0] {
    TAIL_RECIRC = 2'd0,
    TAIL_WRITE  = 2'd1,
    TAIL_SUM    = 2'd2,
    TAIL_TAP    = 2'd3
  } tail_sel_e;

  // One decimal digit add: result[4] is the carry, result[3:0] the digit
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] a,
                                               input logic [3:0] b,
                                               input logic       cin);
    logic [4:0] raw;
    raw = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (raw > 5'd9) raw = raw + 5'd6;
    return raw;
  endfunction
endpackage

// File: rtl/bcd_stack_seq.sv
`timescale 1ns/1ps
module bcd_stack_seq
  import bcd_stack_pkg::*;
#(
  parameter int WORD_BITS = 56,
  localparam int BIT_W = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_en_i,
  output logic [BIT_W-1:0] bit_o,
  output logic [1:0]       slot_o,
  output logic             busy_o,
  output logic             pending_o,
  output logic             frame_end_o,
  output logic             word_start_o,
  output logic             digit_start_o,
  output logic             sum_en_o,
  output tail_sel_e        sel_o
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_BITS - 1);
  localparam logic [1:0]       LAST_SLOT = 2'(LEVELS - 1);

  logic [BIT_W-1:0] bit_q;
  logic [1:0]       slot_q;
  logic             busy_q, pend_q;
  logic             word_end;

  assign word_end    = (bit_q == LAST_BIT);
  assign frame_end_o = word_end && (slot_q == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      bit_q <= word_end ? '0 : bit_q + 1'b1;
      if (word_end) slot_q <= slot_q + 2'd1;
    end
  end

  // Requests are armed while idle and launched on the frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (frame_end_o) begin
      busy_q <= !busy_q && (pend_q || start_i);
      pend_q <= 1'b0;
    end else if (!busy_q && start_i) begin
      pend_q <= 1'b1;
    end
  end

  always_comb begin
    if (busy_q) begin
      unique case (slot_q)
        2'd0:    sel_o = TAIL_SUM;
        2'd1,
        2'd2:    sel_o = TAIL_TAP;
        default: sel_o = TAIL_RECIRC;
      endcase
    end else begin
      sel_o = wr_en_i ? TAIL_WRITE : TAIL_RECIRC;
    end
  end

  assign bit_o         = bit_q;
  assign slot_o        = slot_q;
  assign busy_o        = busy_q;
  assign pending_o     = pend_q;
  assign word_start_o  = (bit_q == '0);
  assign digit_start_o = (bit_q[1:0] == 2'b00);
  assign sum_en_o      = (sel_o == TAIL_SUM);
endmodule

// File: rtl/bcd_stack_adder.sv
`timescale 1ns/1ps
module bcd_stack_adder
  import bcd_stack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               word_start_i,
  input  logic               digit_start_i,
  input  logic [DIGIT_W-1:0] x_dig_i,
  input  logic [DIGIT_W-1:0] y_dig_i,
  output logic               sum_bit_o,
  output logic               carry_o
);
  logic [DIGIT_W-2:0] rest_q;
  logic               cy_q;
  logic               cin;
  logic [4:0]         dsum;

  // Carry into digit 0 is always zero
  assign cin       = word_start_i ? 1'b0 : cy_q;
  assign dsum      = bcd_digit_add(x_dig_i, y_dig_i, cin);
  assign sum_bit_o = digit_start_i ? dsum[0] : rest_q[0];
  assign carry_o   = cy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest_q <= '0;
      cy_q   <= 1'b0;
    end else if (en_i) begin
      if (digit_start_i) begin
        rest_q <= dsum[3:1];
        cy_q   <= dsum[4];
      end else begin
        rest_q <= {1'b0, rest_q[DIGIT_W-2:1]};
      end
    end
  end
endmodule

// File: rtl/bcd_stack_line.sv
`timescale 1ns/1ps
module bcd_stack_line
  import bcd_stack_pkg::*;
#(
  parameter int WORD_BITS = 56
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tail_sel_e          sel_i,
  input  logic               wr_bit_i,
  input  logic               sum_bit_i,
  output logic               head_o,
  output logic               tap_o,
  output logic               top_o,
  output logic [DIGIT_W-1:0] x_dig_o,
  output logic [DIGIT_W-1:0] y_dig_o
);
  localparam int LINE_BITS = LEVELS * WORD_BITS;

  logic [LINE_BITS-1:0] line_q;
  logic                 tail_bit;

  assign head_o  = line_q[0];
  assign tap_o   = line_q[WORD_BITS];
  assign top_o   = line_q[LINE_BITS-1];
  assign x_dig_o = line_q[DIGIT_W-1:0];
  assign y_dig_o = line_q[WORD_BITS+DIGIT_W-1:WORD_BITS];

  always_comb begin
    unique case (sel_i)
      TAIL_WRITE: tail_bit = wr_bit_i;
      TAIL_SUM:   tail_bit = sum_bit_i;
      TAIL_TAP:   tail_bit = line_q[WORD_BITS];
      default:    tail_bit = line_q[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= {tail_bit, line_q[LINE_BITS-1:1]};
  end
endmodule

// File: rtl/bcd_serial_stack.sv
`timescale 1ns/1ps
module bcd_serial_stack
  import bcd_stack_pkg::*;
#(
  parameter int DIGITS = 14,
  localparam int WORD_BITS = DIGITS * DIGIT_W,
  localparam int BIT_W = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  output logic             head_o,
  output logic             tap_o,
  output logic [1:0]       slot_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             busy_o,
  output logic             carry_o
);
  tail_sel_e          tail_sel;
  logic               pending, frame_end, word_start, digit_start, sum_en;
  logic               sum_bit, line_top;
  logic [DIGIT_W-1:0] x_dig, y_dig;

  bcd_stack_seq #(.WORD_BITS(WORD_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_en_i(wr_en_i),
    .bit_o(bit_o), .slot_o(slot_o), .busy_o(busy_o), .pending_o(pending),
    .frame_end_o(frame_end), .word_start_o(word_start),
    .digit_start_o(digit_start), .sum_en_o(sum_en), .sel_o(tail_sel)
  );

  bcd_stack_adder u_add (
    .clk(clk), .rst_n(rst_n), .en_i(sum_en), .word_start_i(word_start),
    .digit_start_i(digit_start), .x_dig_i(x_dig), .y_dig_i(y_dig),
    .sum_bit_o(sum_bit), .carry_o(carry_o)
  );

  bcd_stack_line #(.WORD_BITS(WORD_BITS)) u_line (
    .clk(clk), .rst_n(rst_n), .sel_i(tail_sel), .wr_bit_i(wr_bit_i),
    .sum_bit_i(sum_bit), .head_o(head_o), .tap_o(tap_o), .top_o(line_top),
    .x_dig_o(x_dig), .y_dig_o(y_dig)
  );
endmodule

// File: rtl/bcd_stack_chk.sv
`timescale 1ns/1ps
module bcd_stack_chk
  import bcd_stack_pkg::*;
#(
  parameter int WORD_BITS = 56,
  localparam int BIT_W = $clog2(WORD_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_bit_i,
  input logic             head_o,
  input logic             tap_o,
  input logic [1:0]       slot_o,
  input logic [BIT_W-1:0] bit_o,
  input logic             busy_o,
  input logic             carry_o,
  input logic             pending,
  input logic             frame_end,
  input tail_sel_e        tail_sel,
  input logic             line_top
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  // R2
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_o == LAST_BIT) |=> (bit_o == '0) && (slot_o == $past(slot_o) + 2'd1));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_o != LAST_BIT) |=> (bit_o == $past(bit_o) + 1'b1) && $stable(slot_o));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (slot_o == 2'd0) && (bit_o == '0));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (slot_o == 2'd0) && (bit_o == '0));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !frame_end) |=> busy_o);

  // R10
  no_arm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pending);

  // R10
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (tail_sel != TAIL_WRITE));

  // R3
  recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_sel == TAIL_RECIRC) |=> (line_top == $past(head_o)));

  // R4
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_sel == TAIL_WRITE) |=> (line_top == $past(wr_bit_i)));

  // R7
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_sel == TAIL_TAP) |=> (line_top == $past(tap_o)));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_sel != TAIL_SUM) |=> $stable(carry_o));
endmodule

bind bcd_serial_stack bcd_stack_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_bit_i(wr_bit_i), .head_o(head_o),
  .tap_o(tap_o), .slot_o(slot_o), .bit_o(bit_o), .busy_o(busy_o),
  .carry_o(carry_o), .pending(pending), .frame_end(frame_end),
  .tail_sel(tail_sel), .line_top(line_top)
);

// File: tb/bcd_serial_stack_tb.sv
`timescale 1ns/1ps
module bcd_serial_stack_tb;
  localparam int W     = 56;
  localparam int FRAME = 4 * W;
  localparam longint MOD = 64'd100000000000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, wr_en_i = 1'b0, wr_bit_i = 1'b0;
  logic head_o, tap_o, busy_o, carry_o;
  logic [1:0] slot_o;
  logic [5:0] bit_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_serial_stack u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_en_i(wr_en_i),
    .wr_bit_i(wr_bit_i), .head_o(head_o), .tap_o(tap_o), .slot_o(slot_o),
    .bit_o(bit_o), .busy_o(busy_o), .carry_o(carry_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint bcd2int(input logic [55:0] v);
    longint r = 0;
    for (int d = 13; d >= 0; d--) r = r * 10 + longint'(v[4*d +: 4]);
    return r;
  endfunction

  function automatic logic [55:0] int2bcd(input longint v);
    logic [55:0] r = '0;
    longint t = v;
    for (int d = 0; d < 14; d++) begin
      r[4*d +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic sync_to(input int k, input int b);
    @(negedge clk);
    while (!(slot_o == 2'(k) && bit_o == 6'(b))) @(negedge clk);
  endtask

  task automatic write_reg(input int k, input logic [55:0] v);
    sync_to(k, 0);
    for (int i = 0; i < W; i++) begin
      wr_en_i = 1'b1;
      wr_bit_i = v[i];
      @(negedge clk);
    end
    wr_en_i = 1'b0;
    wr_bit_i = 1'b0;
  endtask

  task automatic read_reg(input int k, input bit use_tap, output logic [55:0] v);
    sync_to(k, 0);
    for (int i = 0; i < W; i++) begin
      v[i] = use_tap ? tap_o : head_o;
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    check(slot_o == 2'd0 && bit_o == 6'd0, "R1 counters in reset", {slot_o, bit_o}, 0);
    check(!busy_o && !carry_o, "R1 busy/carry in reset", {busy_o, carry_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [55:0] v;
      read_reg(k, 1'b0, v);
      check(v == '0, "R1 word zero after reset", v, 0);
    end
  endtask

  task automatic test_counters();
    logic [5:0] pb;
    logic [1:0] ps;
    bit ok = 1'b1;
    @(negedge clk);
    pb = bit_o;
    ps = slot_o;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (pb == 6'd55) begin
        if (bit_o != 6'd0 || slot_o != ps + 2'd1) ok = 1'b0;
      end else if (bit_o != pb + 6'd1 || slot_o != ps) ok = 1'b0;
      pb = bit_o;
      ps = slot_o;
    end
    check(ok, "R2 bit/slot counting", {ps, pb}, 0);
  endtask

  task automatic load_all(input logic [55:0] x, y, z, t);
    write_reg(0, x);
    write_reg(1, y);
    write_reg(2, z);
    write_reg(3, t);
  endtask

  task automatic test_recirc_and_tap();
    logic [55:0] v [4];
    logic [55:0] r;
    v[0] = 56'h31415926535897;
    v[1] = 56'h27182818284590;
    v[2] = 56'h00000000000042;
    v[3] = 56'h98765432109876;
    load_all(v[0], v[1], v[2], v[3]);
    for (int k = 0; k < 4; k++) begin
      read_reg(k, 1'b0, r);
      check(r == v[k], "R2 R4 word readback", r, v[k]);
    end
    repeat (3 * FRAME) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      read_reg(k, 1'b0, r);
      check(r == v[k], "R3 idle recirculation", r, v[k]);
    end
    for (int k = 0; k < 4; k++) begin
      read_reg(k, 1'b1, r);
      check(r == v[(k + 1) % 4], "R5 early tap", r, v[(k + 1) % 4]);
    end
    // R4: rewriting Y alone leaves the others intact
    write_reg(1, 56'h00000000000777);
    read_reg(1, 1'b0, r);
    check(r == 56'h00000000000777, "R4 rewritten word", r, 56'h777);
    read_reg(0, 1'b0, r);
    check(r == v[0], "R4 neighbour X untouched", r, v[0]);
    read_reg(2, 1'b0, r);
    check(r == v[2], "R4 neighbour Z untouched", r, v[2]);
  endtask

  task automatic pop(input logic [55:0] x, y, z, t,
                     input int ss, input int sb, input bit disturb, input string tag);
    longint sum;
    logic [55:0] exp [4];
    logic [55:0] r;
    int waited;
    int nbusy;
    bit exp_c;
    sum = bcd2int(x) + bcd2int(y);
    exp_c = (sum >= MOD);
    exp[0] = int2bcd(sum % MOD);
    exp[1] = z;
    exp[2] = t;
    exp[3] = t;
    load_all(x, y, z, t);
    sync_to(ss, sb);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 1;
    while (!busy_o && waited < 2 * FRAME) begin
      @(negedge clk);
      waited++;
    end
    check(waited == (3 - ss) * W + (55 - sb) + 1, {"R6 start latency ", tag},
          waited, (3 - ss) * W + (55 - sb) + 1);
    check(slot_o == 2'd0 && bit_o == 6'd0, {"R6 busy at frame start ", tag},
          {slot_o, bit_o}, 0);
    nbusy = 0;
    while (busy_o && nbusy < 2 * FRAME) begin
      if (slot_o == 2'd1 && bit_o == 6'd0)
        check(carry_o == exp_c, {"R9 carry ", tag}, carry_o, exp_c);
      if (disturb) begin
        wr_en_i = 1'b1;
        wr_bit_i = 1'b1;
        start_i = (slot_o == 2'd1 && bit_o == 6'd3);
      end
      nbusy++;
      @(negedge clk);
    end
    wr_en_i = 1'b0;
    wr_bit_i = 1'b0;
    start_i = 1'b0;
    check(nbusy == FRAME, {"R6 busy length ", tag}, nbusy, FRAME);
    if (disturb) begin
      int extra = 0;
      for (int i = 0; i < FRAME + 8; i++) begin
        if (busy_o) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R10 start during busy ignored", extra, 0);
    end
    for (int k = 0; k < 4; k++) begin
      read_reg(k, 1'b0, r);
      check(r == exp[k], {"R7 R8 result word ", tag}, r, exp[k]);
    end
    check(carry_o == exp_c, {"R9 carry held ", tag}, carry_o, exp_c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_counters();
    test_recirc_and_tap();
    pop(56'h00000000000123, 56'h00000000000456, 56'h00000000000789,
        56'h00000000002222, 1, 5, 1'b0, "plain");
    pop(56'h99999999999999, 56'h00000000000001, 56'h00000000003333,
        56'h00000000004444, 2, 20, 1'b0, "ripple nines R8");
    pop(56'h00000012345678, 56'h00000087654322, 56'h11111111111111,
        56'h22222222222222, 0, 0, 1'b0, "mid carry R8");
    pop(56'h50000000000000, 56'h50000000000005, 56'h00000000000009,
        56'h00000000000008, 3, 55, 1'b1, "disturbed R10");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule